// File: doc/BRIEF.md
# Masked Even-Lane Duplicate Unit

This execute-stage unit works on a 512-bit vector register built from 32-bit elements. For every pair of elements it copies the even source element into both lanes of the pair. Source lanes 0..7 holding X0..X7 therefore give X0,X0,X2,X2,X4,X4,X6,X6. The copy is bit-exact. No arithmetic is done, so NaN and denormal patterns come out unchanged and no floating-point condition is raised.

The unit has three operating modes, and each treats the upper register bits differently. In legacy mode it writes only the low 128 bits and keeps the rest of the old destination. In plain encoded mode it writes 128 or 256 bits and clears everything above that length. In masked encoded mode it writes 128, 256 or 512 bits under a per-element writemask, using either merge or zero masking, and clears everything above the length. Both encoded modes check a 4-bit reserved specifier field. An illegal encoding raises an undefined-instruction flag, drops the write-enable and returns the old destination unchanged.

The result is registered. A small two-state controller tracks whether a result is present. In state IDLE no result is present. In state RESULT the registered result is presented with `res_valid` high. The transitions are IDLE->RESULT on an issue, RESULT->RESULT on a back-to-back issue, RESULT->IDLE when no issue arrives, and IDLE->IDLE while the unit is quiet.

Top module: `evdup_unit`

## Requirements
- R1: Within the active length, output elements 2n and 2n+1 both equal source element 2n bit for bit, NaN and denormal patterns included.
- R2: `mode` encodes 0 = legacy, 1 = plain encoded, 2 = masked encoded. `vlen` encodes 0 = 128 bits (4 elements), 1 = 256 bits (8), 2 = 512 bits (16). A `mode` of 3, or a `vlen` of 3 in an encoded mode, raises `res_ud`.
- R3: In legacy mode the unit writes elements 0..3, and bits 511:128 keep the old destination value. `vlen` and `rsv_spec` have no effect in this mode, and `res_ud` stays low.
- R4: In plain encoded mode every element above the active length (128 or 256 bits) is zero. A `vlen` of 2 in plain mode raises `res_ud`.
- R5: In masked encoded mode, element j below the length takes the duplicated value when `wmask[j]` is 1 or when `mask_en` is 0.
- R6: In masked encoded mode, an element below the length whose mask bit is 0 (with `mask_en` at 1) keeps its old value when `zero_mask` is 0 and becomes zero when `zero_mask` is 1.
- R7: In masked encoded mode every element at or above the length is zero whatever the mask holds. Mask bits at or above the length have no effect.
- R8: In either encoded mode, a `rsv_spec` other than 4'b1111 raises `res_ud`. Whenever `res_ud` is high, `res_wen` is 0 and `res_dst` equals the old destination that was sampled at issue. Whenever `res_ud` is low and `res_valid` is high, `res_wen` is 1.
- R9: After reset, `res_valid`, `res_wen` and `res_ud` are 0 and `res_dst` is 0. A request sampled with `issue_valid` high at one rising edge produces its result at that same edge, so it is visible with `res_valid` high for the following cycle.
- R10: When `issue_valid` is low at a rising edge, `res_valid` and `res_wen` are low for the next cycle. Back-to-back issues keep `res_valid` high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Request present this cycle |
| src_vec | input | 512 | Source vector, 16 elements of 32 bits |
| old_dst | input | 512 | Current destination register value |
| mode | input | 2 | Operating mode (R2) |
| vlen | input | 2 | Vector length code (R2) |
| wmask | input | 16 | Per-element writemask |
| mask_en | input | 1 | 1 = writemask in use |
| zero_mask | input | 1 | 1 = zero masking, 0 = merge masking |
| rsv_spec | input | 4 | Reserved register-specifier field |
| res_valid | output | 1 | Result present |
| res_dst | output | 512 | New destination value |
| res_wen | output | 1 | Destination write-enable |
| res_ud | output | 1 | Undefined-instruction flag |

## Verification
On every cycle the assertions check the one-cycle timing of `res_valid`. They also check that a flagged result returns the old destination with the write dropped, that legacy results keep the old upper bits, that the low pair is duplicated outside masked mode, and that the upper bits are zero above a short length in the encoded modes. Other behaviour needs the bench's sweeps over every mode, length, masking style, reserved value and mask pattern. These are: the per-element merge versus zero choice, the way mask bits past the length are ignored, the rejection of illegal mode/length pairs, and exact lane contents for NaN and denormal data.

// File: rtl/evdup_pkg.sv
package evdup_pkg;

    typedef enum logic [1:0] {
        MODE_LEGACY = 2'd0,
        MODE_PLAIN  = 2'd1,
        MODE_MASKED = 2'd2,
        MODE_BAD    = 2'd3
    } dup_mode_e;

    typedef enum logic [1:0] {
        LEN_128 = 2'd0,
        LEN_256 = 2'd1,
        LEN_512 = 2'd2,
        LEN_BAD = 2'd3
    } dup_len_e;

    typedef enum logic [1:0] {
        LANE_OLD  = 2'd0,
        LANE_DUP  = 2'd1,
        LANE_ZERO = 2'd2
    } lane_sel_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } dup_state_e;

    localparam logic [3:0] RSV_LEGAL = 4'b1111;

endpackage

// File: rtl/evdup_decode.sv
module evdup_decode
    import evdup_pkg::*;
#(
    parameter int NUM_ELEM = 16,
    parameter int CNT_W    = $clog2(NUM_ELEM + 1)
) (
    input  logic [1:0]       mode,
    input  logic [1:0]       vlen,
    input  logic [3:0]       rsv_spec,
    output logic [CNT_W-1:0] act_elems,
    output logic             ud
);
    localparam int BASE_ELEM = NUM_ELEM / 4;
    localparam logic [CNT_W-1:0] K1 = CNT_W'(BASE_ELEM);
    localparam logic [CNT_W-1:0] K2 = CNT_W'(2 * BASE_ELEM);
    localparam logic [CNT_W-1:0] K4 = CNT_W'(4 * BASE_ELEM);

    logic [CNT_W-1:0] len_elems;
    logic             len_bad;
    logic             rsv_bad;

    always_comb begin
        len_bad = 1'b0;
        unique case (dup_len_e'(vlen))
            LEN_128: len_elems = K1;
            LEN_256: len_elems = K2;
            LEN_512: len_elems = K4;
            default: begin
                len_elems = K1;
                len_bad   = 1'b1;
            end
        endcase
    end

    assign rsv_bad = (rsv_spec != RSV_LEGAL);

    always_comb begin
        unique case (dup_mode_e'(mode))
            MODE_LEGACY: begin
                act_elems = K1;
                ud        = 1'b0;
            end
            MODE_PLAIN: begin
                act_elems = len_elems;
                ud        = rsv_bad || len_bad || (dup_len_e'(vlen) == LEN_512);
            end
            MODE_MASKED: begin
                act_elems = len_elems;
                ud        = rsv_bad || len_bad;
            end
            default: begin
                act_elems = K1;
                ud        = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/evdup_spread.sv
module evdup_spread #(
    parameter int ELEM_W   = 32,
    parameter int NUM_ELEM = 16,
    parameter int REG_W    = ELEM_W * NUM_ELEM
) (
    input  logic [REG_W-1:0] src_vec,
    output logic [REG_W-1:0] dup_vec
);
    localparam int NUM_PAIR = NUM_ELEM / 2;

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        logic [ELEM_W-1:0] even_val;
        assign even_val = src_vec[(2*p)*ELEM_W +: ELEM_W];
        assign dup_vec[(2*p)*ELEM_W   +: ELEM_W] = even_val;
        assign dup_vec[(2*p+1)*ELEM_W +: ELEM_W] = even_val;
    end

endmodule

// File: rtl/evdup_lane_ctl.sv
module evdup_lane_ctl
    import evdup_pkg::*;
#(
    parameter int NUM_ELEM = 16,
    parameter int CNT_W    = $clog2(NUM_ELEM + 1)
) (
    input  logic [1:0]            mode,
    input  logic [CNT_W-1:0]      act_elems,
    input  logic [NUM_ELEM-1:0]   wmask,
    input  logic                  mask_en,
    input  logic                  zero_mask,
    input  logic                  ud,
    output logic [NUM_ELEM-1:0][1:0] lane_sel
);
    for (genvar j = 0; j < NUM_ELEM; j++) begin : g_lane
        localparam logic [CNT_W-1:0] IDX = CNT_W'(j);
        logic      in_len;
        lane_sel_e sel;

        assign in_len = (IDX < act_elems);

        always_comb begin
            if (ud) begin
                sel = LANE_OLD;
            end else begin
                unique case (dup_mode_e'(mode))
                    MODE_LEGACY: sel = in_len ? LANE_DUP : LANE_OLD;
                    MODE_PLAIN:  sel = in_len ? LANE_DUP : LANE_ZERO;
                    MODE_MASKED: begin
                        if (!in_len)
                            sel = LANE_ZERO;
                        else if (!mask_en || wmask[j])
                            sel = LANE_DUP;
                        else if (zero_mask)
                            sel = LANE_ZERO;
                        else
                            sel = LANE_OLD;
                    end
                    default:     sel = LANE_OLD;
                endcase
            end
        end

        assign lane_sel[j] = sel;
    end

endmodule

// File: rtl/evdup_lane_mux.sv
module evdup_lane_mux
    import evdup_pkg::*;
#(
    parameter int ELEM_W   = 32,
    parameter int NUM_ELEM = 16,
    parameter int REG_W    = ELEM_W * NUM_ELEM
) (
    input  logic [NUM_ELEM-1:0][1:0] lane_sel,
    input  logic [REG_W-1:0]         dup_vec,
    input  logic [REG_W-1:0]         old_dst,
    output logic [REG_W-1:0]         new_dst
);
    for (genvar j = 0; j < NUM_ELEM; j++) begin : g_mux
        always_comb begin
            unique case (lane_sel_e'(lane_sel[j]))
                LANE_DUP:  new_dst[j*ELEM_W +: ELEM_W] = dup_vec[j*ELEM_W +: ELEM_W];
                LANE_ZERO: new_dst[j*ELEM_W +: ELEM_W] = '0;
                default:   new_dst[j*ELEM_W +: ELEM_W] = old_dst[j*ELEM_W +: ELEM_W];
            endcase
        end
    end

endmodule

// File: rtl/evdup_unit.sv
module evdup_unit
    import evdup_pkg::*;
#(
    parameter int ELEM_W   = 32,
    parameter int NUM_ELEM = 16,
    parameter int REG_W    = ELEM_W * NUM_ELEM
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_valid,
    input  logic [REG_W-1:0]    src_vec,
    input  logic [REG_W-1:0]    old_dst,
    input  logic [1:0]          mode,
    input  logic [1:0]          vlen,
    input  logic [NUM_ELEM-1:0] wmask,
    input  logic                mask_en,
    input  logic                zero_mask,
    input  logic [3:0]          rsv_spec,
    output logic                res_valid,
    output logic [REG_W-1:0]    res_dst,
    output logic                res_wen,
    output logic                res_ud
);
    localparam int CNT_W = $clog2(NUM_ELEM + 1);

    logic [CNT_W-1:0]          act_elems;
    logic                      dec_ud;
    logic [REG_W-1:0]          dup_vec;
    logic [NUM_ELEM-1:0][1:0]  lane_sel;
    logic [REG_W-1:0]          new_dst;

    dup_state_e                state_q, state_d;
    logic [REG_W-1:0]          dst_q;
    logic                      ud_q;

    evdup_decode #(.NUM_ELEM(NUM_ELEM), .CNT_W(CNT_W)) u_decode (
        .mode      (mode),
        .vlen      (vlen),
        .rsv_spec  (rsv_spec),
        .act_elems (act_elems),
        .ud        (dec_ud)
    );

    evdup_spread #(.ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM), .REG_W(REG_W)) u_spread (
        .src_vec (src_vec),
        .dup_vec (dup_vec)
    );

    evdup_lane_ctl #(.NUM_ELEM(NUM_ELEM), .CNT_W(CNT_W)) u_lane_ctl (
        .mode      (mode),
        .act_elems (act_elems),
        .wmask     (wmask),
        .mask_en   (mask_en),
        .zero_mask (zero_mask),
        .ud        (dec_ud),
        .lane_sel  (lane_sel)
    );

    evdup_lane_mux #(.ELEM_W(ELEM_W), .NUM_ELEM(NUM_ELEM), .REG_W(REG_W)) u_lane_mux (
        .lane_sel (lane_sel),
        .dup_vec  (dup_vec),
        .old_dst  (old_dst),
        .new_dst  (new_dst)
    );

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = issue_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = issue_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q <= '0;
            ud_q  <= 1'b0;
        end else if (issue_valid) begin
            dst_q <= new_dst;
            ud_q  <= dec_ud;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_RESULT: begin
                res_valid = 1'b1;
                res_wen   = !ud_q;
                res_ud    = ud_q;
            end
            default: begin
                res_valid = 1'b0;
                res_wen   = 1'b0;
                res_ud    = 1'b0;
            end
        endcase
        res_dst = dst_q;
    end

endmodule

// File: rtl/evdup_unit_chk.sv
module evdup_unit_chk #(
    parameter int ELEM_W   = 32,
    parameter int NUM_ELEM = 16,
    parameter int REG_W    = ELEM_W * NUM_ELEM
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue_valid,
    input logic [REG_W-1:0] src_vec,
    input logic [REG_W-1:0] old_dst,
    input logic [1:0]       mode,
    input logic [1:0]       vlen,
    input logic [3:0]       rsv_spec,
    input logic             res_valid,
    input logic [REG_W-1:0] res_dst,
    input logic             res_wen,
    input logic             res_ud
);
    localparam int LOW_W  = REG_W / 4;
    localparam int HALF_W = REG_W / 2;

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> res_valid);

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> (!res_valid && !res_wen));

    assert_ud_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ud) |-> (!res_wen && res_dst == $past(old_dst)));

    assert_wen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ud) |-> res_wen);

    assert_rsv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(mode) != 2'd0 && $past(rsv_spec) != 4'b1111) |-> res_ud);

    assert_legacy_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(mode) == 2'd0) |->
            (!res_ud && res_dst[REG_W-1:LOW_W] == $past(old_dst[REG_W-1:LOW_W])));

    assert_pair_dup_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ud && $past(mode) != 2'd2) |->
            (res_dst[ELEM_W-1:0] == $past(src_vec[ELEM_W-1:0]) &&
             res_dst[2*ELEM_W-1:ELEM_W] == $past(src_vec[ELEM_W-1:0])));

    assert_plain_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ud && $past(mode) == 2'd1 && $past(vlen) == 2'd0) |->
            (res_dst[REG_W-1:LOW_W] == '0));

    assert_masked_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ud && $past(mode) == 2'd2 && $past(vlen) != 2'd2) |->
            (res_dst[REG_W-1:HALF_W] == '0));

endmodule

bind evdup_unit evdup_unit_chk #(
    .ELEM_W   (ELEM_W),
    .NUM_ELEM (NUM_ELEM),
    .REG_W    (REG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .src_vec     (src_vec),
    .old_dst     (old_dst),
    .mode        (mode),
    .vlen        (vlen),
    .rsv_spec    (rsv_spec),
    .res_valid   (res_valid),
    .res_dst     (res_dst),
    .res_wen     (res_wen),
    .res_ud      (res_ud)
);

// File: tb/evdup_unit_tb.sv
`timescale 1ns/1ps
module evdup_unit_tb;
    localparam int EW = 32;
    localparam int NE = 16;
    localparam int RW = EW * NE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0;
    logic [RW-1:0] src_vec = '0;
    logic [RW-1:0] old_dst = '0;
    logic [1:0]    mode = '0;
    logic [1:0]    vlen = '0;
    logic [NE-1:0] wmask = '0;
    logic          mask_en = 1'b0;
    logic          zero_mask = 1'b0;
    logic [3:0]    rsv_spec = 4'hF;
    logic          res_valid;
    logic [RW-1:0] res_dst;
    logic          res_wen;
    logic          res_ud;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    evdup_unit u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .src_vec(src_vec), .old_dst(old_dst), .mode(mode), .vlen(vlen),
        .wmask(wmask), .mask_en(mask_en), .zero_mask(zero_mask),
        .rsv_spec(rsv_spec), .res_valid(res_valid), .res_dst(res_dst),
        .res_wen(res_wen), .res_ud(res_ud)
    );

    function automatic bit model_ud(input logic [1:0] m, input logic [1:0] l, input logic [3:0] r);
        if (m == 2'd3) return 1'b1;
        if (m == 2'd0) return 1'b0;
        if (r != 4'hF || l == 2'd3) return 1'b1;
        return (m == 2'd1 && l == 2'd2);
    endfunction

    function automatic logic [RW-1:0] model_dst(
        input logic [RW-1:0] s, input logic [RW-1:0] o, input logic [1:0] m,
        input logic [1:0] l, input logic [NE-1:0] k, input logic me, input logic zm,
        input logic [3:0] r);
        logic [RW-1:0] d;
        int kl;
        d = o;
        if (model_ud(m, l, r)) return d;
        kl = (m == 2'd0) ? 4 : (4 << l);
        for (int j = 0; j < NE; j++) begin
            logic [EW-1:0] dv;
            dv = s[(j - (j % 2))*EW +: EW];
            if (j >= kl) begin
                if (m != 2'd0) d[j*EW +: EW] = '0;
            end else if (m != 2'd2 || !me || k[j]) begin
                d[j*EW +: EW] = dv;
            end else if (zm) begin
                d[j*EW +: EW] = '0;
            end
        end
        return d;
    endfunction

    task automatic check(input string req, input logic [RW-1:0] got, input logic [RW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drives one request at a falling edge, then checks at the next falling edge
    task automatic run_op(input int tag, input logic [1:0] m, input logic [1:0] l,
                          input logic [NE-1:0] k, input logic me, input logic zm,
                          input logic [3:0] r);
        logic [RW-1:0] s, o, exp_d;
        bit exp_u;
        string req;
        for (int i = 0; i < NE; i++) begin
            s[i*EW +: EW] = {tag[7:0], 8'hC3, 8'(i), 8'h5A};
            o[i*EW +: EW] = {8'h55, tag[7:0], 8'(i), 8'hE1};
        end
        if (tag % 3 == 0) begin
            s[0 +: EW]    = 32'h7FC0_0001; // quiet NaN payload
            s[2*EW +: EW] = 32'h0000_0001; // denormal
        end
        src_vec = s; old_dst = o; mode = m; vlen = l; wmask = k;
        mask_en = me; zero_mask = zm; rsv_spec = r; issue_valid = 1'b1;
        exp_d = model_dst(s, o, m, l, k, me, zm, r);
        exp_u = model_ud(m, l, r);
        if (exp_u) req = (m == 2'd3 || l == 2'd3) ? "R2" : "R8";
        else if (m == 2'd0) req = "R1+R3";
        else if (m == 2'd1) req = "R1+R4";
        else req = "R1+R5+R6+R7";
        @(negedge clk);
        check("R9 valid", {{(RW-1){1'b0}}, res_valid}, {{(RW-1){1'b0}}, 1'b1});
        check({req, " ud"}, {{(RW-1){1'b0}}, res_ud}, {{(RW-1){1'b0}}, exp_u});
        check("R8 wen", {{(RW-1){1'b0}}, res_wen}, {{(RW-1){1'b0}}, !exp_u});
        check({req, " dst"}, res_dst, exp_d);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R9: watchdog expired, got hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stimulus
        logic [NE-1:0] masks [4];
        logic [3:0]    rsvs  [3];
        int            tag;
        masks[0] = 16'h0000; masks[1] = 16'hFFFF;
        masks[2] = 16'hA5C3; masks[3] = 16'h0F0E;
        rsvs[0] = 4'hF; rsvs[1] = 4'h0; rsvs[2] = 4'h7;
        tag = 0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset valid", {{(RW-1){1'b0}}, res_valid}, '0);
        check("R9 reset wen",   {{(RW-1){1'b0}}, res_wen}, '0);
        check("R9 reset ud",    {{(RW-1){1'b0}}, res_ud}, '0);
        check("R9 reset dst",   res_dst, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: no issue keeps result absent
        check("R10 idle", {{(RW-1){1'b0}}, res_valid}, '0);
        for (int m = 0; m < 4; m++)
            for (int l = 0; l < 4; l++)
                for (int me = 0; me < 2; me++)
                    for (int zm = 0; zm < 2; zm++)
                        for (int r = 0; r < 3; r++)
                            for (int k = 0; k < 4; k++) begin
                                run_op(tag, 2'(m), 2'(l), masks[k], 1'(me), 1'(zm), rsvs[r]);
                                tag++;
                            end
        issue_valid = 1'b0;
        @(negedge clk);
        // R10: valid and write-enable drop after the issue stream stops
        check("R10 valid drop", {{(RW-1){1'b0}}, res_valid}, '0);
        check("R10 wen drop",   {{(RW-1){1'b0}}, res_wen}, '0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule